// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Burst SRAM

This block is a synthesizable, clock-accurate model of a synchronous static RAM whose data bus never needs a dead cycle when it changes direction. Every access has two phases. In the address phase the block samples the address and the control inputs on a rising clock edge. In the data phase, the cycle right after, read data flows straight out of the array, or write data is taken from the input bus at the next edge. Reads and writes can therefore follow each other on every cycle with no idle cycles between them.

An advance/load input chooses between two actions. It can start a new access at the presented address, or it can continue the current access at the next address of a wrapping four-beat linear burst, which keeps the direction chosen at the last load. A chip select turns off new loads, and an advance that follows a deselect is a no-operation. An active-low clock-enable stalls the whole block. The pad-level bus is split into a write-data input, a read-data output and a drive flag, and output enable gates the drive flag. The word is made of byte lanes, and each lane has its own active-low write enable.

Top module: `zbt_sram`

## Requirements
- R1: When a read access is captured at a rising edge, `rdata_o` carries the stored word at the access address during the following cycle. `drive_o` is 1 in that cycle whenever `oe_n_i` is 0.
- R2: When a write access is captured at a rising edge, the word on `wdata_i` is stored at the next rising edge at the access address. That edge must have `hold_i` = 0.
- R3: Byte lane k (bits 8k+7..8k) is written only when `byte_wr_n_i[k]` is 0 at the data-phase edge. Any lane whose bit is 1 keeps its old contents.
- R4: With `adv_i` = 0, `cs_n_i` = 0 and `hold_i` = 0, a new access starts at `addr_i`. It is a read when `rd_i` = 1 and a write when `rd_i` = 0.
- R5: With `adv_i` = 1 during a live burst, the next access uses the previous address with its two low bits incremented modulo 4. The upper bits are unchanged and the direction of the last load is kept. `addr_i` and `rd_i` are ignored. After four beats the address returns to the loaded value.
- R6: A read may follow a write, and a write may follow a read, on consecutive cycles with no idle cycle between them, and each access gives the correct data.
- R7: With `adv_i` = 0 and `cs_n_i` = 1 (a deselect), `drive_o` is 0 in the following cycle and the array is not written.
- R8: With `adv_i` = 1 after a deselect (a no-operation), `drive_o` stays 0 and the array is not written.
- R9: `drive_o` is 0 in every cycle in which `oe_n_i` is 1. When `drive_o` is 0, `rdata_o` is all zeros.
- R10: While `hold_i` = 1 at an edge, no input is sampled, the burst address and pending data phase hold, and the array is not written.
- R11: After reset no access is pending, `drive_o` is 0 and every word of the array reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | 1 = freeze the block for this edge (clock enable, active low) |
| cs_n_i | input | 1 | Active-low chip select used on a load |
| adv_i | input | 1 | 1 = continue burst, 0 = load new address |
| rd_i | input | 1 | On a load: 1 = read, 0 = write |
| addr_i | input | ADDR_W | Word address for a load |
| byte_wr_n_i | input | LANES | Active-low per-lane write enables, sampled in the data phase |
| wdata_i | input | LANES*LANE_W | Write data, sampled in the data phase |
| oe_n_i | input | 1 | Active-low output enable |
| rdata_o | output | LANES*LANE_W | Read data (zero when not driven) |
| drive_o | output | 1 | 1 = the data bus would be driven by the RAM |

## Verification
The assertions run on every cycle. They check that output enable gates the drive flag, that a stall freezes the pending phase and the burst address, and that a deselect or a no-operation leaves the bus undriven. They also check that each burst advance moves only the two low address bits up by one while keeping the direction. The stored contents are another matter: lane masking, turnaround correctness and the fact that deselects, no-operations and stalled writes leave the array untouched show up only when the bench's scenarios read the data back. The bench does this against its own reference array during directed sweeps and a long random mix.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    // kind of data phase pending in the cycle after an address phase
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

    // number of low address bits the linear burst walks through
    localparam int unsigned BURST_BITS = 2;
endpackage

// File: rtl/zbt_burst_ctrl.sv
module zbt_burst_ctrl
    import zbt_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              hold_i,
    input  logic              cs_n_i,
    input  logic              adv_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    output phase_e            phase_o,
    output logic [ADDR_W-1:0] ph_addr_o,
    output logic              live_o
);
    localparam int unsigned UPPER_W = ADDR_W - BURST_BITS;

    typedef struct packed {
        logic              live;
        logic              dir_rd;
        logic [ADDR_W-1:0] addr;
        phase_e            phase;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [BURST_BITS-1:0] step_lo;
    logic [UPPER_W-1:0]    keep_hi;

    always_comb begin
        step_lo = st_q.addr[BURST_BITS-1:0] + {{(BURST_BITS-1){1'b0}}, 1'b1};
        keep_hi = st_q.addr[ADDR_W-1:BURST_BITS];
        st_d    = st_q;
        if (!hold_i) begin
            if (!adv_i) begin
                if (!cs_n_i) begin
                    st_d.live   = 1'b1;
                    st_d.dir_rd = rd_i;
                    st_d.addr   = addr_i;
                    st_d.phase  = rd_i ? PH_READ : PH_WRITE;
                end else begin
                    st_d.live  = 1'b0;
                    st_d.phase = PH_IDLE;
                end
            end else if (st_q.live) begin
                st_d.addr  = {keep_hi, step_lo};
                st_d.phase = st_q.dir_rd ? PH_READ : PH_WRITE;
            end else begin
                st_d.phase = PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{live: 1'b0, dir_rd: 1'b0, addr: '0, phase: PH_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o   = st_q.phase;
    assign ph_addr_o = st_q.addr;
    assign live_o    = st_q.live;
endmodule

// File: rtl/zbt_mem_array.sv
module zbt_mem_array #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     we_i,
    input  logic [LANES-1:0]         lane_wr_n_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [LANES*LANE_W-1:0]  wdata_i,
    output logic [LANES*LANE_W-1:0]  rdata_o
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cell_q [DEPTH];
        logic              lane_we;

        assign lane_we = we_i && !lane_wr_n_i[g];

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                for (int i = 0; i < DEPTH; i++) begin
                    cell_q[i] <= '0;
                end
            end else if (lane_we) begin
                cell_q[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end

        // flow-through: the read path has no output register
        assign rdata_o[g*LANE_W +: LANE_W] = cell_q[addr_i];
    end
endmodule

// File: rtl/zbt_out_stage.sv
module zbt_out_stage
    import zbt_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  phase_e            phase_i,
    input  logic              oe_n_i,
    input  logic [DATA_W-1:0] arr_data_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              drive_o
);
    logic drive_d;

    always_comb begin
        drive_d = (phase_i == PH_READ) && !oe_n_i;
        rdata_o = drive_d ? arr_data_i : '0;
        drive_o = drive_d;
    end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 8
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    hold_i,
    input  logic                    cs_n_i,
    input  logic                    adv_i,
    input  logic                    rd_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES-1:0]        byte_wr_n_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic                    oe_n_i,
    output logic [LANES*LANE_W-1:0] rdata_o,
    output logic                    drive_o
);
    localparam int unsigned DATA_W = LANES * LANE_W;

    phase_e              ph_kind;
    logic [ADDR_W-1:0]   ph_addr;
    logic                burst_live;
    logic                arr_we;
    logic [DATA_W-1:0]   arr_rdata;

    zbt_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hold_i    (hold_i),
        .cs_n_i    (cs_n_i),
        .adv_i     (adv_i),
        .rd_i      (rd_i),
        .addr_i    (addr_i),
        .phase_o   (ph_kind),
        .ph_addr_o (ph_addr),
        .live_o    (burst_live)
    );

    // the write data phase commits at the edge that ends it, unless stalled
    assign arr_we = (ph_kind == PH_WRITE) && !hold_i;

    zbt_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .we_i        (arr_we),
        .lane_wr_n_i (byte_wr_n_i),
        .addr_i      (ph_addr),
        .wdata_i     (wdata_i),
        .rdata_o     (arr_rdata)
    );

    zbt_out_stage #(.DATA_W(DATA_W)) u_out (
        .phase_i    (ph_kind),
        .oe_n_i     (oe_n_i),
        .arr_data_i (arr_rdata),
        .rdata_o    (rdata_o),
        .drive_o    (drive_o)
    );
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk
    import zbt_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              hold_i,
    input logic              cs_n_i,
    input logic              adv_i,
    input logic              oe_n_i,
    input logic              drive_o,
    input phase_e            phase,
    input logic [ADDR_W-1:0] ph_addr,
    input logic              live
);
    // R9: output enable high always blocks the drive flag
    p_oe_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        oe_n_i |-> !drive_o);

    // R10: a stalled edge changes none of the pending state
    p_stall_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_i |=> ($stable(phase) && $stable(ph_addr) && $stable(live)));

    // R7: a deselect leaves the next cycle idle and undriven
    p_deselect_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hold_i && !adv_i && cs_n_i) |=> (!drive_o && phase == PH_IDLE));

    // R8: advancing with no live burst is a no-operation
    p_nop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hold_i && adv_i && !live) |=> (phase == PH_IDLE && !drive_o));

    // R5: a burst advance walks only the two low bits and keeps direction
    p_burst_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hold_i && adv_i && live) |=>
            (ph_addr[1:0] == 2'($past(ph_addr[1:0]) + 2'd1)
             && ph_addr[ADDR_W-1:2] == $past(ph_addr[ADDR_W-1:2])
             && phase == $past(phase)));
endmodule

bind zbt_sram zbt_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (hold_i),
    .cs_n_i  (cs_n_i),
    .adv_i   (adv_i),
    .oe_n_i  (oe_n_i),
    .drive_o (drive_o),
    .phase   (ph_kind),
    .ph_addr (ph_addr),
    .live    (burst_live)
);

// File: tb/zbt_sram_test.sv
`timescale 1ns/1ps
module zbt_sram_test;
    localparam int unsigned AW  = 6;
    localparam int unsigned NL  = 4;
    localparam int unsigned LW  = 8;
    localparam int unsigned DW  = NL * LW;
    localparam int unsigned DEP = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hold = 1'b0, cs_n = 1'b1, adv = 1'b0, rd = 1'b0, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [NL-1:0] bwn = '1;
    logic [DW-1:0] wd = '0;
    logic [DW-1:0] rdata;
    logic          drive;

    int checks = 0;
    int fails = 0;

    // reference model state
    logic [DW-1:0] ref_mem [DEP];
    int            m_ph = 0;      // 0 idle, 1 read, 2 write
    logic          m_live = 1'b0;
    logic          m_dir = 1'b0;
    logic [AW-1:0] m_addr = '0;

    always #10 clk = ~clk;   // 50 MHz

    zbt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
        .clk_i(clk), .rst_ni(rst_n), .hold_i(hold), .cs_n_i(cs_n),
        .adv_i(adv), .rd_i(rd), .addr_i(addr), .byte_wr_n_i(bwn),
        .wdata_i(wd), .oe_n_i(oe_n), .rdata_o(rdata), .drive_o(drive)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive inputs after the falling edge, check, then step the model
    task automatic cyc(input logic h, input logic c, input logic a, input logic r,
                       input logic [AW-1:0] ad, input logic [DW-1:0] d,
                       input logic [NL-1:0] bw, input logic oe, input string tag);
        logic          exp_drv;
        logic [DW-1:0] exp_dat;
        @(negedge clk);
        hold = h; cs_n = c; adv = a; rd = r; addr = ad; wd = d; bwn = bw; oe_n = oe;
        #2;
        exp_drv = (m_ph == 1) && !oe;
        exp_dat = exp_drv ? ref_mem[m_addr] : '0;
        check(drive == exp_drv, {tag, " drive"}, {{(DW-1){1'b0}}, drive},
              {{(DW-1){1'b0}}, exp_drv});
        check(rdata == exp_dat, {tag, " data"}, rdata, exp_dat);
        @(posedge clk);
        if (!h) begin
            if (m_ph == 2) begin
                for (int l = 0; l < NL; l++) begin
                    if (!bw[l]) ref_mem[m_addr][l*LW +: LW] = d[l*LW +: LW];
                end
            end
            if (!a) begin
                if (!c) begin
                    m_live = 1'b1; m_dir = r; m_addr = ad; m_ph = r ? 1 : 2;
                end else begin
                    m_live = 1'b0; m_ph = 0;
                end
            end else if (m_live) begin
                m_addr[1:0] = m_addr[1:0] + 2'd1;
                m_ph = m_dir ? 1 : 2;
            end else begin
                m_ph = 0;
            end
        end
    endtask

    // shorthand for common cycles
    task automatic ld(input logic r, input logic [AW-1:0] ad, input logic [DW-1:0] d,
                      input string tag);
        cyc(1'b0, 1'b0, 1'b0, r, ad, d, '0, 1'b0, tag);
    endtask

    task automatic bst(input logic [DW-1:0] d, input string tag);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 6'h2a, d, '0, 1'b0, tag);
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEP; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11: after reset, idle bus and zero contents
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 6'd0, '0, '1, 1'b0, "R11 idle");
        ld(1'b1, 6'd5, '0, "R11 load read");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 6'd0, '0, '1, 1'b0, "R11 reads zero");

        // R1 R2 R4: single write then read back, sweep of all addresses
        for (int i = 0; i < DEP; i++) ld(1'b0, 6'(i), 32'h1000_0000 + 32'(i * 7), "R2 R4 write sweep");
        ld(1'b1, 6'd0, 32'h1000_0000 + 32'((DEP - 1) * 7), "R2 last data");
        for (int i = 1; i < DEP; i++) ld(1'b1, 6'(i), '0, "R1 R4 read sweep");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 6'd0, '0, '1, 1'b0, "R1 last read");

        // R3: lane-masked writes
        for (int m = 0; m < (1 << NL); m++) begin
            ld(1'b0, 6'd9, '0, "R3 load");
            cyc(1'b0, 1'b0, 1'b0, 1'b1, 6'd9, 32'hA5C3_0000 + 32'(m * 257), 4'(m), 1'b0, "R3 masked data");
            cyc(1'b0, 1'b1, 1'b0, 1'b1, 6'd0, '0, '1, 1'b0, "R3 readback");
        end

        // R5: burst write from an address with low bits 01, then burst read with wrap
        ld(1'b0, 6'd21, '0, "R5 burst write load");
        bst(32'hB000_0001, "R5 beat");
        bst(32'hB000_0002, "R5 beat");
        bst(32'hB000_0003, "R5 beat");
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 6'd21, 32'hB000_0004, '0, 1'b0, "R5 last beat, load read");
        for (int k = 0; k < 6; k++) cyc(1'b0, 1'b1, 1'b1, 1'b0, 6'h3f, '0, '1, 1'b0, "R5 burst read wrap");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 6'd0, '0, '1, 1'b0, "R5 end");

        // R6: alternating read and write with no idle cycle, same address
        for (int k = 0; k < 8; k++) begin
            ld(1'b0, 6'd33, 32'(k), "R6 write");
            ld(1'b1, 6'd33, 32'hC600_0000 + 32'(k), "R6 read after write");
        end
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 6'd0, '0, '1, 1'b0, "R6 end");

        // R7 R8: deselect and no-ops with data and lanes active must not write
        ld(1'b0, 6'd40, '0, "R7 setup write");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 6'd40, 32'hDEAD_0040, '0, 1'b0, "R7 deselect");
        for (int k = 0; k < 3; k++)
            cyc(1'b0, 1'b0, 1'b1, 1'b0, 6'd40, 32'hBAD0_0000 + 32'(k), '0, 1'b0, "R8 nop");
        ld(1'b1, 6'd40, 32'hBAD1_0000, "R8 load read");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 6'd0, 32'hBAD2_0000, '0, 1'b0, "R7 R8 readback");

        // R9: output enable high during read data phases
        ld(1'b1, 6'd21, '0, "R9 load");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 6'd0, '0, '1, 1'b1, "R9 oe high");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 6'd0, '0, '1, 1'b0, "R9 oe low");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 6'd0, '0, '1, 1'b1, "R9 oe high");

        // R10: stall with a pending read, then a pending write
        ld(1'b1, 6'd22, '0, "R10 load read");
        for (int k = 0; k < 3; k++)
            cyc(1'b1, 1'b0, 1'b0, 1'b0, 6'd1, 32'hEE00_0000, '0, 1'b0, "R10 stall read");
        ld(1'b0, 6'd50, '0, "R10 load write");
        for (int k = 0; k < 3; k++)
            cyc(1'b1, 1'b0, 1'b0, 1'b1, 6'd2, 32'hEE11_0000 + 32'(k), '0, 1'b0, "R10 stall write");
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 6'd50, 32'h5050_5050, '0, 1'b0, "R10 release write");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 6'd0, '0, '1, 1'b0, "R10 readback");

        // random mix of loads, bursts, deselects, no-ops and stalls
        for (int k = 0; k < 5000; k++) begin
            logic h, c, a, r, o;
            h = ($urandom_range(0, 9) == 0);
            c = ($urandom_range(0, 6) == 0);
            a = ($urandom_range(0, 9) < 4);
            r = $urandom_range(0, 1) == 1;
            o = ($urandom_range(0, 9) == 0);
            cyc(h, c, a, r, 6'($urandom), 32'($urandom), 4'($urandom), o,
                "R1 R2 R3 R5 R6 R7 R8 R9 R10 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule